// File: doc/BRIEF.md
# Fan Tachometer Speed Meter

This block turns the tach output of a 4-wire fan into a speed figure in revolutions per minute. The tach line is brought into the clock domain by a synchroniser and then qualified by a glitch filter. Rising edges are counted over a fixed gate window. At the end of each window the count is scaled to RPM and stored in a 16-bit result register, and a one-cycle strobe marks each new result.

Fans report either two or four tach pulses per revolution, so one select input picks the scale factor. Measurement runs only while the tach enable input is high. While it is low the result reads zero and no strobe is issued. A count too large for the result register is clamped to the all-ones value.

Top module: `fan_tach_meter`

## Requirements
- R1: After reset, `rpm_o` is 0 and `rpm_valid_o` is low.
- R2: While `tach_en` is low, `rpm_o` reads 0 from the next cycle on and `rpm_valid_o` stays low whatever `tach_in` does.
- R3: After `tach_en` rises, the first `rpm_valid_o` pulse comes exactly GATE_CYCLES cycles later, and further pulses follow every GATE_CYCLES cycles.
- R4: With `ppr_sel` = 0 (two pulses per revolution), a window with N qualified rising edges yields `rpm_o` = N*30.
- R5: With `ppr_sel` = 1 (four pulses per revolution), a window with N qualified rising edges yields `rpm_o` = N*15.
- R6: When the scaled count exceeds 65535, `rpm_o` reads 65535.
- R7: A window with no qualified rising edge still produces a `rpm_valid_o` pulse, with `rpm_o` = 0.
- R8: After synchronisation, a tach level must hold for FILT_LEN consecutive cycles before it is accepted. Shorter pulses add no count.
- R9: `rpm_valid_o` is high for exactly one cycle. `rpm_o` changes only on a cycle that has that pulse, or when measurement is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tach_en | input | 1 | Measurement enable; low clears the result |
| ppr_sel | input | 1 | 0: two pulses per revolution, 1: four |
| tach_in | input | 1 | Raw fan tach line, asynchronous |
| rpm_o | output | RPM_W | Last measured speed in RPM, saturated |
| rpm_valid_o | output | 1 | One-cycle strobe when `rpm_o` is refreshed |

## Verification
The bench builds the block with a 14000-cycle gate and a 2-cycle filter instead of a one-second gate. This makes many full windows affordable, including a window that holds enough 6-cycle pulses (2190) to push the two-pulse scaling past 65535. With a 2-cycle filter, single-cycle glitches are rejected while 2-cycle pulses still count, so both sides of the filter threshold are exercised. The 100 MHz default gate and other filter lengths use the same logic with different counter limits.

// File: rtl/tach_pkg.sv
package tach_pkg;

   typedef enum logic {
      PPR_TWO  = 1'b0,
      PPR_FOUR = 1'b1
   } ppr_e;

   localparam int unsigned SEC_PER_MIN = 60;
   localparam int unsigned WEIGHT_W    = 6;

   // RPM contributed by one rising edge inside a one-second window
   function automatic logic [WEIGHT_W-1:0] edge_weight(input ppr_e sel);
      return (sel == PPR_FOUR) ? WEIGHT_W'(SEC_PER_MIN / 4) : WEIGHT_W'(SEC_PER_MIN / 2);
   endfunction

endpackage

// File: rtl/tach_sync.sv
module tach_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   if (STAGES < 2) begin : g_bad
      $error("tach_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/tach_glitch_filter.sv
module tach_glitch_filter #(
   parameter int unsigned FILT_LEN = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise_o
);
   logic level;

   if (FILT_LEN <= 1) begin : g_bypass
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) level <= 1'b0;
         else        level <= din;
      end
      assign rise_o = din && !level;
   end else begin : g_filter
      localparam int unsigned CW = $clog2(FILT_LEN);
      logic [CW-1:0] run;
      logic          ripe;

      assign ripe   = (din != level) && (run == CW'(FILT_LEN - 1));
      assign rise_o = ripe && din;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            level <= 1'b0;
            run   <= '0;
         end else if (din == level) begin
            run <= '0;
         end else if (ripe) begin
            level <= din;
            run   <= '0;
         end else begin
            run <= run + 1'b1;
         end
      end
   end
endmodule

// File: rtl/tach_gate_counter.sv
module tach_gate_counter #(
   parameter int unsigned GATE_CYCLES = 100_000_000,
   parameter int unsigned CNT_W       = $clog2(GATE_CYCLES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             edge_i,
   output logic             gate_end_o,
   output logic [CNT_W-1:0] total_o
);
   localparam int unsigned GW = $clog2(GATE_CYCLES);

   logic [GW-1:0]    gate;
   logic [CNT_W-1:0] cnt;

   assign gate_end_o = en && (gate == GW'(GATE_CYCLES - 1));
   assign total_o    = cnt + CNT_W'(edge_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate <= '0;
         cnt  <= '0;
      end else if (!en || gate_end_o) begin
         gate <= '0;
         cnt  <= '0;
      end else begin
         gate <= gate + 1'b1;
         cnt  <= total_o;
      end
   end
endmodule

// File: rtl/fan_tach_meter.sv
module fan_tach_meter #(
   parameter int unsigned GATE_CYCLES = 100_000_000,
   parameter int unsigned FILT_LEN    = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned RPM_W       = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tach_en,
   input  logic             ppr_sel,
   input  logic             tach_in,
   output logic [RPM_W-1:0] rpm_o,
   output logic             rpm_valid_o
);
   import tach_pkg::*;

   localparam int unsigned CNT_W  = $clog2(GATE_CYCLES + 1);
   localparam int unsigned PROD_W = CNT_W + WEIGHT_W;

   if (GATE_CYCLES < 2) begin : g_bad_gate
      $error("fan_tach_meter: GATE_CYCLES must be at least 2");
   end
   if (RPM_W < 6) begin : g_bad_w
      $error("fan_tach_meter: RPM_W too narrow");
   end

   logic             tach_s;
   logic             rise;
   logic             gate_end;
   logic [CNT_W-1:0] total;
   logic [PROD_W-1:0] prod;
   logic [RPM_W-1:0] rpm_next;

   tach_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .din(tach_in), .dout(tach_s)
   );

   tach_glitch_filter #(.FILT_LEN(FILT_LEN)) i_filt (
      .clk(clk), .rst_n(rst_n), .din(tach_s), .rise_o(rise)
   );

   tach_gate_counter #(.GATE_CYCLES(GATE_CYCLES), .CNT_W(CNT_W)) i_gate (
      .clk(clk), .rst_n(rst_n), .en(tach_en), .edge_i(rise),
      .gate_end_o(gate_end), .total_o(total)
   );

   assign prod = PROD_W'(total) * PROD_W'(edge_weight(ppr_e'(ppr_sel)));

   if (PROD_W > RPM_W) begin : g_sat
      assign rpm_next = (|prod[PROD_W-1:RPM_W]) ? {RPM_W{1'b1}} : prod[RPM_W-1:0];
   end else begin : g_nosat
      assign rpm_next = RPM_W'(prod);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rpm_o       <= '0;
         rpm_valid_o <= 1'b0;
      end else if (!tach_en) begin
         rpm_o       <= '0;
         rpm_valid_o <= 1'b0;
      end else begin
         rpm_valid_o <= gate_end;
         if (gate_end) rpm_o <= rpm_next;
      end
   end
endmodule

// File: rtl/fan_tach_meter_chk.sv
module fan_tach_meter_chk #(
   parameter int unsigned RPM_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tach_en,
   input logic [RPM_W-1:0] rpm_o,
   input logic             rpm_valid_o
);
   AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !tach_en |=> (rpm_o == '0)); // R2

   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !tach_en |=> !rpm_valid_o); // R2

   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rpm_valid_o |=> !rpm_valid_o); // R9

   AST_RPM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (tach_en && $past(tach_en) && !rpm_valid_o) |-> $stable(rpm_o)); // R9

   AST_SCALE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (rpm_valid_o && rpm_o != {RPM_W{1'b1}}) |-> ((rpm_o % 15) == 0)); // R5

   always_comb begin
      if (!rst_n) begin
         AST_RESET_CLEAR: assert (rpm_o == '0 && !rpm_valid_o); // R1
      end
   end
endmodule

bind fan_tach_meter fan_tach_meter_chk #(.RPM_W(RPM_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .tach_en(tach_en),
   .rpm_o(rpm_o), .rpm_valid_o(rpm_valid_o)
);

// File: tb/test_fan_tach_meter.sv
module test_fan_tach_meter;
   localparam int unsigned GATE = 14000;
   localparam int unsigned FILT = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tach_en = 1'b0;
   logic        ppr_sel = 1'b0;
   logic        tach_in = 1'b0;
   logic [15:0] rpm_o;
   logic        rpm_valid_o;

   int tests = 0;
   int fails = 0;
   int valid_seen = 0;

   always #5 clk = ~clk;

   fan_tach_meter #(.GATE_CYCLES(GATE), .FILT_LEN(FILT)) i_fan_tach_meter (
      .clk(clk), .rst_n(rst_n), .tach_en(tach_en), .ppr_sel(ppr_sel),
      .tach_in(tach_in), .rpm_o(rpm_o), .rpm_valid_o(rpm_valid_o)
   );

   always @(negedge clk) if (rpm_valid_o) valid_seen++;

   function automatic int exp_rpm(input int n, input logic sel);
      int v;
      v = n * (sel ? 15 : 30);
      return (v > 65535) ? 65535 : v;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic pulses(input int n, input int hi, input int lo);
      for (int i = 0; i < n; i++) begin
         tach_in = 1'b1;
         repeat (hi) @(negedge clk);
         tach_in = 1'b0;
         repeat (lo) @(negedge clk);
      end
   endtask

   task automatic wait_valid(output int cyc);
      cyc = 0;
      do begin
         @(negedge clk);
         cyc++;
      end while (!rpm_valid_o);
   endtask

   task automatic measure(input string req, input int n, input int hi, input int lo, input logic sel);
      int c;
      ppr_sel = sel;
      pulses(n, hi, lo);
      wait_valid(c);
      check(req, rpm_o, exp_rpm(n, sel));
   endtask

   initial begin
      int c;
      int snap;
      int hold;
      void'($urandom(32'd20417));
      repeat (3) @(negedge clk);
      check("R1 rpm", rpm_o, 0);
      check("R1 valid", rpm_valid_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      tach_en = 1'b1;
      wait_valid(c);
      check("R3 first window", c, GATE);
      check("R7 empty window", rpm_o, 0);

      measure("R4 two ppr", 100, 3, 3, 1'b0);
      measure("R5 four ppr", 137, 4, 2, 1'b1);

      wait_valid(c);
      check("R3 period", c, GATE);
      check("R7 idle window", rpm_o, 0);

      // single-cycle glitches interleaved with 2-cycle pulses
      ppr_sel = 1'b0;
      for (int i = 0; i < 40; i++) begin
         pulses(1, 1, 4);
         pulses(1, 2, 4);
      end
      wait_valid(c);
      check("R8 glitch filter", rpm_o, exp_rpm(40, 1'b0));

      measure("R6 saturation", 2190, 3, 3, 1'b0);

      for (int k = 0; k < 3; k++) begin
         int n = $urandom_range(1, 800);
         logic s = 1'($urandom_range(0, 1));
         int h = 2 + $urandom_range(0, 2);
         int l = 2 + $urandom_range(0, 2);
         hold = rpm_o;
         ppr_sel = s;
         pulses(n, h, l);
         check("R9 hold", rpm_o, hold);
         wait_valid(c);
         check(s ? "R5 random" : "R4 random", rpm_o, exp_rpm(n, s));
      end

      tach_en = 1'b0;
      @(negedge clk);
      check("R2 cleared", rpm_o, 0);
      snap = valid_seen;
      pulses(60, 3, 3);
      repeat (20) @(negedge clk);
      check("R2 no strobe", valid_seen - snap, 0);
      check("R2 stays zero", rpm_o, 0);

      tach_en = 1'b1;
      wait_valid(c);
      check("R3 re-enable", c, GATE);
      check("R7 after re-enable", rpm_o, 0);
      @(negedge clk);
      check("R9 one cycle", rpm_valid_o, 0);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule